// File: doc/BRIEF.md
# Raster Timing and Blank Latch

This block is the timing heart of a video display processor. A horizontal counter walks through every master-clock cycle of a scanline, and a line counter steps once per scanline and wraps at the frame length. The frame length is chosen by a standard-select input: 313 lines for 50 Hz, 262 lines for 60 Hz. With the default parameters a scanline is 1368 master clocks, which is exactly 228 CPU cycles for a CPU that runs at one sixth of the master rate.

From the two counters the block decodes the per-line phases (sync, border and active) and the vertical phases (active lines and vertical sync). It also produces a flag that marks the lines on which the next line's objects are evaluated, and a one-cycle frame interrupt. All of these outputs are registered and line up with the counter values in the same cycle.

The display-enable control bit is not applied at once. It is sampled only at the point where the left border gives way to the active area. A write made in the middle of a line therefore changes the picture from the following line onward.

Top module: `raster_timer`

## Requirements
- R1: `hpos` counts up by one every clock from 0 to LINE_CLKS-1 (default 1368) and then returns to 0.
- R2: `vpos` changes only in the cycle where `hpos` returns to 0. It then steps by one, or returns to 0 if it was on the last line of the frame. The last line is LINES_50-1 (default 312) when `pal_sel`=1 and LINES_60-1 (default 261) when `pal_sel`=0.
- R3: Exactly one horizontal phase is high in every cycle, and it is valid together with the `hpos` of the same cycle. `hsync` covers hpos < HSYNC_W. `hactive` covers ACT_START <= hpos < ACT_START+ACT_W. `hborder` covers every other position.
- R4: `vactive` is high for vpos < ACTIVE_LINES (default 192). `vsync` is high for VSYNC_FIRST <= vpos < VSYNC_FIRST+VSYNC_LINES.
- R5: `eval_line` is high on the last line of the frame and on lines 0 to ACTIVE_LINES-2. These are the lines on which the following line's objects are evaluated, so line 0 is evaluated on the line before it.
- R6: `frame_irq` is high for exactly one cycle per frame, the cycle with hpos=0 and vpos=ACTIVE_LINES.
- R7: In the cycle where `hpos` first equals ACT_START, `blank` holds the inverse of the `disp_en` value that was present at the clock edge which moved `hpos` from ACT_START-1.
- R8: `blank` changes in no other cycle. A `disp_en` change made anywhere else in a line has no effect until the next sampling point.
- R9: While `rst` is high, the next clock gives hpos=0, vpos=0, `blank`=1 (blanked) and `frame_irq`=0.
- R10: If `pal_sel` drops to 0 while `vpos` is beyond the 60 Hz last line, `vpos` returns to 0 at the end of the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| pal_sel | input | 1 | 1 selects the 50 Hz frame length, 0 selects the 60 Hz frame length |
| disp_en | input | 1 | display-enable control bit (1 shows the picture) |
| hpos | output | HW (11) | cycle position within the line |
| vpos | output | VW (9) | line number within the frame |
| hsync | output | 1 | horizontal sync phase |
| hborder | output | 1 | border phase (left or right) |
| hactive | output | 1 | active horizontal phase |
| vactive | output | 1 | line belongs to the active picture |
| vsync | output | 1 | vertical sync lines |
| eval_line | output | 1 | the next line's objects are evaluated on this line |
| frame_irq | output | 1 | one-cycle frame interrupt pulse |
| blank | output | 1 | latched blanking state |

## Verification
The assertions check on every cycle the behaviours that are local in time:
- the counter stepping and wrap;
- line changes only at the start of a line;
- exactly one horizontal phase;
- the single-cycle interrupt and its position;
- the sampling of `blank` at one point only, and the reset values.

Other properties can only be shown by the bench's scenarios. These are the frame lengths under each standard select, the vertical decode of the active, sync and evaluation lines, and the fact that mid-line `disp_en` toggles at many different positions take effect on the following line. The early wrap after a mid-frame switch to the shorter frame is also shown there. The bench sweeps whole frames of a reduced configuration and compares every output against arithmetic expectations on every cycle. A default-size instance runs beside it to confirm the 1368-cycle line.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic hsync;
    logic hborder;
    logic hactive;
    logic vactive;
    logic vsync;
    logic eval_next;
    logic irq;
  } raster_flags_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int LINE_CLKS = 1368,
  parameter int HW        = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_q,
  output logic [HW-1:0] h_nxt,
  output logic          h_wrap
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);

  always_comb begin
    h_wrap = (h_q == H_LAST);
    h_nxt  = h_wrap ? '0 : h_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) h_q <= '0;
    else     h_q <= h_nxt;
  end
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int LINES_50 = 313,
  parameter int LINES_60 = 262,
  parameter int VW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pal_sel,
  input  logic          h_wrap,
  output logic [VW-1:0] v_q,
  output logic [VW-1:0] v_nxt,
  output logic [VW-1:0] v_last
);
  localparam logic [VW-1:0] LAST50 = VW'(LINES_50 - 1);
  localparam logic [VW-1:0] LAST60 = VW'(LINES_60 - 1);

  always_comb begin
    v_last = pal_sel ? LAST50 : LAST60;
    if (!h_wrap)           v_nxt = v_q;
    else if (v_q >= v_last) v_nxt = '0;
    else                    v_nxt = v_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= v_nxt;
  end
endmodule

// File: rtl/raster_phase.sv
module raster_phase
  import raster_pkg::*;
#(
  parameter int HW           = 11,
  parameter int VW           = 9,
  parameter int HSYNC_W      = 104,
  parameter int ACT_START    = 284,
  parameter int ACT_W        = 1024,
  parameter int ACTIVE_LINES = 192,
  parameter int VSYNC_FIRST  = 216,
  parameter int VSYNC_LINES  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_nxt,
  input  logic [VW-1:0] v_nxt,
  input  logic [VW-1:0] v_last,
  output raster_flags_t flags
);
  localparam logic [HW-1:0] SYNC_END = HW'(HSYNC_W);
  localparam logic [HW-1:0] ACT_BEG  = HW'(ACT_START);
  localparam logic [HW-1:0] ACT_FIN  = HW'(ACT_START + ACT_W);
  localparam logic [VW-1:0] VACT_END = VW'(ACTIVE_LINES);
  localparam logic [VW-1:0] EVAL_END = VW'(ACTIVE_LINES - 1);
  localparam logic [VW-1:0] VS_BEG   = VW'(VSYNC_FIRST);
  localparam logic [VW-1:0] VS_FIN   = VW'(VSYNC_FIRST + VSYNC_LINES);

  function automatic raster_flags_t decode(input logic [HW-1:0] h,
                                           input logic [VW-1:0] v,
                                           input logic [VW-1:0] last);
    raster_flags_t f;
    f.hsync     = (h < SYNC_END);
    f.hactive   = (h >= ACT_BEG) && (h < ACT_FIN);
    f.hborder   = !f.hsync && !f.hactive;
    f.vactive   = (v < VACT_END);
    f.vsync     = (v >= VS_BEG) && (v < VS_FIN);
    f.eval_next = (v == last) || (v < EVAL_END);
    f.irq       = (h == '0) && (v == VACT_END);
    return f;
  endfunction

  // flags are decoded from the next counter values so that the registered
  // result lines up with the registered counters
  always_ff @(posedge clk) begin
    if (rst) flags <= decode('0, '0, v_last);
    else     flags <= decode(h_nxt, v_nxt, v_last);
  end
endmodule

// File: rtl/raster_blank.sv
module raster_blank #(
  parameter int HW        = 11,
  parameter int ACT_START = 284
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_nxt,
  input  logic          disp_en,
  output logic          blank
);
  localparam logic [HW-1:0] SAMPLE_AT = HW'(ACT_START);

  always_ff @(posedge clk) begin
    if (rst)                    blank <= 1'b1;
    else if (h_nxt == SAMPLE_AT) blank <= !disp_en;
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int LINE_CLKS    = 1368,
  parameter int LINES_50     = 313,
  parameter int LINES_60     = 262,
  parameter int HSYNC_W      = 104,
  parameter int ACT_START    = 284,
  parameter int ACT_W        = 1024,
  parameter int ACTIVE_LINES = 192,
  parameter int VSYNC_FIRST  = 216,
  parameter int VSYNC_LINES  = 3,
  parameter int HW           = $clog2(LINE_CLKS),
  parameter int VW           = $clog2((LINES_50 > LINES_60) ? LINES_50 : LINES_60)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pal_sel,
  input  logic          disp_en,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          hsync,
  output logic          hborder,
  output logic          hactive,
  output logic          vactive,
  output logic          vsync,
  output logic          eval_line,
  output logic          frame_irq,
  output logic          blank
);
  logic [HW-1:0] h_nxt;
  logic          h_wrap;
  logic [VW-1:0] v_nxt;
  logic [VW-1:0] v_last;
  raster_flags_t flags;

  raster_hcount #(.LINE_CLKS(LINE_CLKS), .HW(HW)) u_hcount (
    .clk(clk), .rst(rst), .h_q(hpos), .h_nxt(h_nxt), .h_wrap(h_wrap)
  );

  raster_vcount #(.LINES_50(LINES_50), .LINES_60(LINES_60), .VW(VW)) u_vcount (
    .clk(clk), .rst(rst), .pal_sel(pal_sel), .h_wrap(h_wrap),
    .v_q(vpos), .v_nxt(v_nxt), .v_last(v_last)
  );

  raster_phase #(
    .HW(HW), .VW(VW), .HSYNC_W(HSYNC_W), .ACT_START(ACT_START), .ACT_W(ACT_W),
    .ACTIVE_LINES(ACTIVE_LINES), .VSYNC_FIRST(VSYNC_FIRST), .VSYNC_LINES(VSYNC_LINES)
  ) u_phase (
    .clk(clk), .rst(rst), .h_nxt(h_nxt), .v_nxt(v_nxt), .v_last(v_last), .flags(flags)
  );

  raster_blank #(.HW(HW), .ACT_START(ACT_START)) u_blank (
    .clk(clk), .rst(rst), .h_nxt(h_nxt), .disp_en(disp_en), .blank(blank)
  );

  always_comb begin
    hsync     = flags.hsync;
    hborder   = flags.hborder;
    hactive   = flags.hactive;
    vactive   = flags.vactive;
    vsync     = flags.vsync;
    eval_line = flags.eval_next;
    frame_irq = flags.irq;
  end
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int LINE_CLKS    = 1368,
  parameter int ACT_START    = 284,
  parameter int ACTIVE_LINES = 192,
  parameter int HW           = 11,
  parameter int VW           = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_en,
  input logic [HW-1:0] hpos,
  input logic [VW-1:0] vpos,
  input logic          hsync,
  input logic          hborder,
  input logic          hactive,
  input logic          frame_irq,
  input logic          blank
);
  localparam logic [HW-1:0] H_LAST   = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_SAMPLE = HW'(ACT_START);
  localparam logic [HW-1:0] H_PRE    = HW'(ACT_START - 1);
  localparam logic [VW-1:0] V_IRQ    = VW'(ACTIVE_LINES);

  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hpos == H_LAST |=> hpos == '0);
  // R1
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    hpos != H_LAST |=> hpos == $past(hpos) + 1'b1);
  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hpos != '0 |-> $stable(vpos));
  // R3
  hphase_one_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({hsync, hborder, hactive}) == 1);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);
  // R6
  irq_place_chk: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> (hpos == '0) && (vpos == V_IRQ));
  // R7
  blank_sample_chk: assert property (@(posedge clk) disable iff (rst)
    hpos == H_PRE |=> blank == !$past(disp_en));
  // R8
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hpos != H_SAMPLE |-> $stable(blank));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (hpos == '0) && (vpos == '0) && blank && !frame_irq);
endmodule

bind raster_timer raster_timer_chk #(
  .LINE_CLKS(LINE_CLKS), .ACT_START(ACT_START), .ACTIVE_LINES(ACTIVE_LINES),
  .HW(HW), .VW(VW)
) u_raster_chk (
  .clk(clk), .rst(rst), .disp_en(disp_en), .hpos(hpos), .vpos(vpos),
  .hsync(hsync), .hborder(hborder), .hactive(hactive),
  .frame_irq(frame_irq), .blank(blank)
);

// File: tb/test_raster_timer.sv
`timescale 1ns/1ps
module test_raster_timer;
  // reduced configuration for full-frame sweeps
  localparam int S_LINE = 40, S_L50 = 13, S_L60 = 10, S_SYNC = 4, S_ACT0 = 10,
                 S_ACTW = 24, S_VACT = 6, S_VS0 = 8, S_VSN = 1;
  localparam int SHW = $clog2(S_LINE), SVW = $clog2(S_L50);
  localparam int D_LINE = 1368, D_ACT0 = 284;
  localparam int N_CYC = 6000;

  logic clk = 1'b0, rst = 1'b1, pal_sel = 1'b0, disp_en = 1'b0;
  logic [SHW-1:0] hpos;
  logic [SVW-1:0] vpos;
  logic hsync, hborder, hactive, vactive, vsync, eval_line, frame_irq, blank;
  logic [10:0] d_hpos;
  logic [8:0]  d_vpos;
  logic d_hs, d_hb, d_ha, d_va, d_vs, d_ev, d_irq, d_blank;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  raster_timer #(
    .LINE_CLKS(S_LINE), .LINES_50(S_L50), .LINES_60(S_L60), .HSYNC_W(S_SYNC),
    .ACT_START(S_ACT0), .ACT_W(S_ACTW), .ACTIVE_LINES(S_VACT),
    .VSYNC_FIRST(S_VS0), .VSYNC_LINES(S_VSN)
  ) i_raster_timer (
    .clk(clk), .rst(rst), .pal_sel(pal_sel), .disp_en(disp_en),
    .hpos(hpos), .vpos(vpos), .hsync(hsync), .hborder(hborder), .hactive(hactive),
    .vactive(vactive), .vsync(vsync), .eval_line(eval_line),
    .frame_irq(frame_irq), .blank(blank)
  );

  raster_timer i_raster_timer_dflt (
    .clk(clk), .rst(rst), .pal_sel(1'b1), .disp_en(1'b1),
    .hpos(d_hpos), .vpos(d_vpos), .hsync(d_hs), .hborder(d_hb), .hactive(d_ha),
    .vactive(d_va), .vsync(d_vs), .eval_line(d_ev), .frame_irq(d_irq), .blank(d_blank)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int eh, ev, eb, last, dh, dv, db;
    bit switched, pending;
    eh = 0; ev = 0; eb = 1; dh = 0; dv = 0; db = 1;
    switched = 0; pending = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 hpos", int'(hpos), 0);
    chk("R9 vpos", int'(vpos), 0);
    chk("R9 blank", int'(blank), 1);
    chk("R9 frame_irq", int'(frame_irq), 0);
    chk("R9 hsync", int'(hsync), 1);
    chk("R9 dflt hpos", int'(d_hpos), 0);
    chk("R9 dflt blank", int'(d_blank), 1);
    rst = 1'b0;
    for (int n = 0; n < N_CYC; n++) begin
      @(negedge clk);
      // reduced model, inputs as seen at the last edge
      last = pal_sel ? S_L50 - 1 : S_L60 - 1;
      if (eh == S_LINE - 1) begin
        eh = 0;
        ev = (ev >= last) ? 0 : ev + 1;
      end else eh++;
      if (eh == S_ACT0) eb = disp_en ? 0 : 1;
      // default-size model
      if (dh == D_LINE - 1) begin dh = 0; dv++; end else dh++;
      if (dh == D_ACT0) db = 0;

      chk("R1 hpos", int'(hpos), eh);
      chk("R2 vpos", int'(vpos), ev);
      chk("R3 hsync", int'(hsync), int'(eh < S_SYNC));
      chk("R3 hactive", int'(hactive), int'(eh >= S_ACT0 && eh < S_ACT0 + S_ACTW));
      chk("R3 hborder", int'(hborder), int'(!(eh < S_SYNC) && !(eh >= S_ACT0 && eh < S_ACT0 + S_ACTW)));
      chk("R4 vactive", int'(vactive), int'(ev < S_VACT));
      chk("R4 vsync", int'(vsync), int'(ev >= S_VS0 && ev < S_VS0 + S_VSN));
      chk("R5 eval_line", int'(eval_line), int'(ev == last || ev < S_VACT - 1));
      chk("R6 frame_irq", int'(frame_irq), int'(eh == 0 && ev == S_VACT));
      chk("R7 R8 blank", int'(blank), eb);
      chk("R1 dflt hpos", int'(d_hpos), dh);
      chk("R2 dflt vpos", int'(d_vpos), dv);
      chk("R7 dflt blank", int'(d_blank), db);
      if (pending && eh == 0) begin
        // R10 early wrap after switching to the shorter frame
        chk("R10 early wrap vpos", int'(vpos), 0);
        pending = 0;
      end

      // stimulus for the next edge
      if (n % 29 == 28) disp_en = ~disp_en;
      if (n == 1200) pal_sel = 1'b1;
      if (!switched && n > 2400 && ev == 11 && eh == 5) begin
        pal_sel = 1'b0;
        switched = 1;
        pending = 1;
      end
    end
    chk("R10 switch exercised", int'(switched), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule